// File: doc/BRIEF.md
# Codec Cold Reset Timer

This block drives the active-low cold reset line of an audio codec. The codec stops its serial bit clock while its reset is held, so no timing can be based on that clock. The block therefore runs entirely on the free-running system clock. A one-cycle trigger pulse, normally the debounced system reset, starts a reset window. The window holds the line low for a fixed, parameterised number of system-clock cycles and then releases it.

The codec can lose its clock if it is reset for too long or too often. Two guards prevent this. The low time is exact and cannot be stretched by further triggers. After each release, a cool-down period follows in which triggers are ignored. A busy flag shows the window to downstream logic, which can wait on it before expecting the bit clock to come back. The block has no reset input of its own: its counter and state start from declared initial values, and the trigger is the only thing that moves them.

Top module: `codec_cold_reset`

## Requirements
- R1: After power-up and before the first trigger, `codec_rst_n` is 1 and `busy` is 0.
- R2: When `trig` is sampled high by a rising clock edge while the block is idle, `codec_rst_n` goes to 0 at that edge. It stays 0 for exactly `LOW_CYCLES` clock cycles and then returns to 1. It is never held low longer than that.
- R3: A `trig` sampled high while `codec_rst_n` is 0 is ignored. The current window is neither restarted nor extended, so its total low time is still `LOW_CYCLES`.
- R4: For `GUARD_CYCLES` cycles after release, `trig` is ignored and `codec_rst_n` stays 1. This includes a `trig` sampled on the edge `LOW_CYCLES + GUARD_CYCLES` cycles after the accepting edge.
- R5: A `trig` sampled on the edge `LOW_CYCLES + GUARD_CYCLES + 1` cycles after the accepting edge, or on any later edge, starts a new full window. If `trig` is held high continuously, the line is released for exactly `GUARD_CYCLES + 1` samples between windows.
- R6: `busy` is 1 exactly in the cycles in which `codec_rst_n` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock; all timing is counted on it |
| trig | input | 1 | Request for a cold reset, normally a one-cycle pulse |
| codec_rst_n | output | 1 | Registered active-low reset to the codec |
| busy | output | 1 | High while the reset window is active |

## Verification
The bench measures each low window cycle by cycle. A design with an off-by-one counter would give `LOW_CYCLES ± 1`. A design that restarts on a trigger arriving mid-window would give a window longer than `LOW_CYCLES`.

The cool-down is probed on both sides of its edge. One trigger lands on the last ignored edge and another on the first accepting edge. A guard that is one cycle short would fire early, and one that is one cycle long would miss the accept.

Holding `trig` high checks the spacing between back-to-back windows. A design without a guard would reset the codec continuously. `busy` is compared with the line on every sample, which catches a flag that lags or leads the line by a cycle.

// File: rtl/codec_cold_reset.sv
module codec_cold_reset #(
  parameter int LOW_CYCLES   = 34,
  parameter int GUARD_CYCLES = 256
) (
  input  logic clk,
  input  logic trig,
  output logic codec_rst_n,
  output logic busy
);
  localparam int MAXC = (LOW_CYCLES > GUARD_CYCLES) ? LOW_CYCLES : GUARD_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] LOW_LAST   = CW'(LOW_CYCLES - 1);
  localparam logic [CW-1:0] GUARD_LAST = CW'(GUARD_CYCLES - 1);

  typedef enum logic [1:0] {PH_IDLE, PH_HOLD, PH_COOL} phase_t;

  phase_t        phase = PH_IDLE;
  logic [CW-1:0] cnt   = '0;
  logic          line  = 1'b1;

  always_ff @(posedge clk) begin
    case (phase)
      PH_IDLE: if (trig) begin
        phase <= PH_HOLD;
        cnt   <= LOW_LAST;
        line  <= 1'b0;
      end
      PH_HOLD: if (cnt == '0) begin
        phase <= PH_COOL;
        cnt   <= GUARD_LAST;
        line  <= 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
      PH_COOL: if (cnt == '0) phase <= PH_IDLE;
               else           cnt   <= cnt - 1'b1;
      default: phase <= PH_IDLE;
    endcase
  end

  assign codec_rst_n = line;
  assign busy        = (phase == PH_HOLD);
endmodule

// File: rtl/codec_cold_reset_chk.sv
module codec_cold_reset_chk #(
  parameter int LOW_CYCLES   = 34,
  parameter int GUARD_CYCLES = 256
) (
  input logic clk,
  input logic trig,
  input logic codec_rst_n,
  input logic busy
);
  logic        started = 1'b0;
  logic [31:0] lowrun  = '0;
  logic [31:0] highrun = 32'(GUARD_CYCLES + 1);

  always_ff @(posedge clk) begin
    started <= 1'b1;
    if (!codec_rst_n) lowrun <= lowrun + 1;
    else              lowrun <= '0;
    if (codec_rst_n) begin
      if (highrun < 32'(GUARD_CYCLES + 1)) highrun <= highrun + 1;
    end else begin
      highrun <= '0;
    end
  end

  assert_busy_tracks_line_R6: assert property (@(posedge clk) disable iff (!started)
    busy == !codec_rst_n);

  assert_low_bounded_R2: assert property (@(posedge clk) disable iff (!started)
    !codec_rst_n |-> lowrun < 32'(LOW_CYCLES));

  assert_full_window_R3: assert property (@(posedge clk) disable iff (!started)
    $rose(codec_rst_n) |-> lowrun == 32'(LOW_CYCLES));

  assert_guard_respected_R4: assert property (@(posedge clk) disable iff (!started)
    $fell(codec_rst_n) |-> highrun >= 32'(GUARD_CYCLES + 1));

  assert_accept_after_guard_R5: assert property (@(posedge clk) disable iff (!started)
    (codec_rst_n && trig && highrun >= 32'(GUARD_CYCLES)) |=> !codec_rst_n);
endmodule

bind codec_cold_reset codec_cold_reset_chk #(
  .LOW_CYCLES(LOW_CYCLES), .GUARD_CYCLES(GUARD_CYCLES)
) u_chk (
  .clk(clk), .trig(trig), .codec_rst_n(codec_rst_n), .busy(busy)
);

// File: tb/sim_codec_cold_reset.sv
module sim_codec_cold_reset;
  localparam int LOW   = 34;
  localparam int GUARD = 256;

  logic clk = 1'b0;
  logic trig = 1'b0;
  logic codec_rst_n, busy;
  int   errors = 0;
  int   checks = 0;
  bit   done = 0;

  always #2 clk = ~clk;

  codec_cold_reset #(.LOW_CYCLES(LOW), .GUARD_CYCLES(GUARD)) u0 (
    .clk(clk), .trig(trig), .codec_rst_n(codec_rst_n), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure_low(output int c);
    c = 0;
    while (codec_rst_n == 1'b0 && c < LOW * 4) begin
      if (busy !== 1'b1) check(0, "R6 busy during low", int'(busy), 1);
      c++;
      @(negedge clk);
    end
    check(busy == 1'b0, "R6 busy after release", int'(busy), 0);
  endtask

  task automatic t_idle;
    repeat (5) @(negedge clk);
    check(codec_rst_n == 1'b1, "R1 line idle", int'(codec_rst_n), 1);
    check(busy == 1'b0, "R1 busy idle", int'(busy), 0);
  endtask

  task automatic t_single;
    int c;
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    check(codec_rst_n == 1'b0, "R2 line falls", int'(codec_rst_n), 0);
    check(busy == 1'b1, "R6 busy rises", int'(busy), 1);
    measure_low(c);
    check(c == LOW, "R2 low length", c, LOW);
    repeat (GUARD + 4) @(negedge clk);
  endtask

  task automatic t_retrig;
    int c, c2;
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    c = 0;
    repeat (10) begin c++; @(negedge clk); end
    trig = 1'b1; c++;
    @(negedge clk); trig = 1'b0;
    measure_low(c2);
    check(c + c2 == LOW, "R3 window not extended", c + c2, LOW);
    repeat (GUARD + 4) @(negedge clk);
  endtask

  task automatic t_guard_edges;
    int c;
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    measure_low(c);
    check(c == LOW, "R2 low length", c, LOW);
    trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    check(codec_rst_n == 1'b1, "R4 early trigger ignored", int'(codec_rst_n), 1);
    repeat (GUARD - 2) @(negedge clk);
    check(codec_rst_n == 1'b1, "R4 line held high in guard", int'(codec_rst_n), 1);
    trig = 1'b1;
    @(negedge clk);
    check(codec_rst_n == 1'b1, "R4 last guarded edge ignored", int'(codec_rst_n), 1);
    @(negedge clk); trig = 1'b0;
    check(codec_rst_n == 1'b0, "R5 first free edge accepted", int'(codec_rst_n), 0);
    measure_low(c);
    check(c == LOW, "R5 new full window", c, LOW);
    repeat (GUARD + 4) @(negedge clk);
  endtask

  task automatic t_held;
    int c, h;
    @(negedge clk); trig = 1'b1;
    @(negedge clk);
    measure_low(c);
    check(c == LOW, "R2 held trigger window", c, LOW);
    h = 0;
    while (codec_rst_n == 1'b1 && h < GUARD * 2) begin h++; @(negedge clk); end
    check(h == GUARD + 1, "R5 spacing with held trigger", h, GUARD + 1);
    measure_low(c);
    check(c == LOW, "R5 second window", c, LOW);
    trig = 1'b0;
    repeat (GUARD + 4) @(negedge clk);
    check(codec_rst_n == 1'b1, "R4 quiet after trigger drops", int'(codec_rst_n), 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_idle();
    t_single();
    t_retrig();
    t_guard_edges();
    t_held();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule